// File: doc/BRIEF.md
# Parallel-Port Register Access Engine

This block is the host-side engine that reads and writes a single register of a disk adapter through a legacy parallel port. It drives an 8-bit data port and a control port, and it samples the status port, the control readback and the data port. A request carries a read/write flag, a bank select, a 7-bit register index, a write byte and a 2-bit transfer mode. The engine plays the strobe sequence that belongs to that request, rebuilds the read byte from the samples it took, and pulses `done`.

Before the register address goes onto the data lines it is XORed with a key. The key depends on the mode and on the direction. The two narrow read modes carry the byte back in pieces on the status lines (and, in the split mode, also on the control readback), and the engine puts those pieces together. Every port update is held for a programmable number of extra clock cycles, so the slow peripheral sees stable levels.

Top module: `ppa_regio_engine`

## Requirements
- R1: The driven address is the 7-bit index with bit 7 set to the bank select, so bank 1 (control registers) adds 0x80 and bank 0 (task file) adds nothing; the mode key is XORed onto that byte.
- R2: Mode 0 read (nibble): the port writes are data=A^0x39, ctrl=0x01, ctrl=0x03, data=A^0x39, ctrl=0x01, ctrl=0x04. Status is sampled after the second data write and again after the following ctrl=0x01. The result is {second[7:4], first[7:4]}.
- R3: Mode 1 read (5/3 split): with r=A^0x31, the port writes are data=r, ctrl=0x01, data=r&0x37, ctrl=0x03, ctrl=0x05, data=r|0xF0, ctrl=0x04. Status and control readback are sampled together before the final ctrl write. The result is {ctrl[3:1], status[7:3]}.
- R4: Mode 2 or 3 read (byte): the port writes are data=A^0x29, ctrl=0x01, ctrl=0x21, ctrl=0x23, ctrl=0x04. The data port is sampled before the final ctrl write, and that sample is the result.
- R5: A write in any mode performs data=A^0x19, ctrl=0x01, data=wdata, ctrl=0x03, ctrl=0x04.
- R6: Each port update is held for hold_cfg+1 cycles and each sample takes one cycle. `done` is therefore high exactly U*(hold_cfg+1)+S cycles after the accepting edge, where U is the number of port updates and S the number of samples of the sequence.
- R7: `pp_data_oe` is low whenever control bit 5 is set, and high otherwise.
- R8: A request is accepted only while `busy` is low. A request presented while busy is dropped and changes neither the port sequence nor the result.
- R9: `done` is high for exactly one cycle per transaction. `rdata` carries the read result from that cycle on and holds it until the next read completes.
- R10: Reset sets ctrl=0x04, data=0x00, `pp_data_oe`=1, `busy`=0 and `done`=0. While idle, ctrl stays at 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_bank | input | 1 | 0 = task-file bank, 1 = control bank |
| req_index | input | 7 | Register index |
| req_wdata | input | 8 | Byte to write |
| req_mode | input | 2 | 0 nibble, 1 split 5/3, 2 or 3 byte |
| hold_cfg | input | HOLD_W | Extra cycles each port update is held |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Rebuilt read byte |
| pp_data_o | output | 8 | Data port drive value |
| pp_data_oe | output | 1 | Data port output enable |
| pp_ctrl_o | output | 8 | Control port value |
| pp_data_i | input | 8 | Data port sample |
| pp_status_i | input | 8 | Status port sample |
| pp_ctrl_i | input | 8 | Control port readback |

## Verification
The accepting edge is the reference point. `done` and the new `rdata` are due exactly U*(hold_cfg+1)+S edges after it, where U and S are the numbers of port updates and samples of the sequence: 6/2 for a nibble read, 7/1 for a split read, 5/1 for a byte read and 5/0 for a write. The bench counts falling edges from the accept and compares the count at which `done` is first seen with that number. It also records every change of the data and control ports at falling edges and compares that trace with the sequence each requirement lists. `done` must be low one cycle after it was seen, `rdata` must still hold its value then, and a request dropped during a transaction must raise no `busy` within eight cycles after the done.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  localparam int BYTE_W = 8;
  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_DATA     = 3'd0,
    OP_CTRL     = 3'd1,
    OP_SMP_HI   = 3'd2,
    OP_SMP_LO   = 3'd3,
    OP_SMP_PAIR = 3'd4,
    OP_SMP_BUS  = 3'd5
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [BYTE_W-1:0] val;
    logic              last;
  } step_t;

  localparam logic [1:0] MODE_NIB   = 2'd0;
  localparam logic [1:0] MODE_SPLIT = 2'd1;

  localparam logic [BYTE_W-1:0] KEY_RD_NIB   = 8'h39;
  localparam logic [BYTE_W-1:0] KEY_RD_SPLIT = 8'h31;
  localparam logic [BYTE_W-1:0] KEY_RD_BYTE  = 8'h29;
  localparam logic [BYTE_W-1:0] KEY_WR       = 8'h19;

  localparam logic [BYTE_W-1:0] SPLIT_AND = 8'h37;
  localparam logic [BYTE_W-1:0] SPLIT_OR  = 8'hF0;

  localparam logic [BYTE_W-1:0] CTL_IDLE  = 8'h04;
  localparam logic [BYTE_W-1:0] CTL_ARM   = 8'h01;
  localparam logic [BYTE_W-1:0] CTL_GO    = 8'h03;
  localparam logic [BYTE_W-1:0] CTL_SPLIT = 8'h05;
  localparam logic [BYTE_W-1:0] CTL_REV_A = 8'h21;
  localparam logic [BYTE_W-1:0] CTL_REV_B = 8'h23;

  localparam int DIR_BIT = 5;

  function automatic step_t mk_step(op_e o, logic [BYTE_W-1:0] v, logic l);
    step_t s;
    s.op   = o;
    s.val  = v;
    s.last = l;
    return s;
  endfunction

endpackage

// File: rtl/ppa_step_seq.sv
module ppa_step_seq
  import ppa_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  input  logic              is_write,
  input  logic [1:0]        mode,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output step_t             step
);

  logic [BYTE_W-1:0] a_wr, a_nib, a_spl, a_byt;

  always_comb begin
    a_wr  = addr ^ KEY_WR;
    a_nib = addr ^ KEY_RD_NIB;
    a_spl = addr ^ KEY_RD_SPLIT;
    a_byt = addr ^ KEY_RD_BYTE;
    step  = mk_step(OP_CTRL, CTL_IDLE, 1'b1);
    if (is_write) begin
      case (idx)
        3'd0:    step = mk_step(OP_DATA, a_wr, 1'b0);
        3'd1:    step = mk_step(OP_CTRL, CTL_ARM, 1'b0);
        3'd2:    step = mk_step(OP_DATA, wdata, 1'b0);
        3'd3:    step = mk_step(OP_CTRL, CTL_GO, 1'b0);
        default: step = mk_step(OP_CTRL, CTL_IDLE, 1'b1);
      endcase
    end else if (mode == MODE_NIB) begin
      case (idx)
        3'd0:    step = mk_step(OP_DATA, a_nib, 1'b0);
        3'd1:    step = mk_step(OP_CTRL, CTL_ARM, 1'b0);
        3'd2:    step = mk_step(OP_CTRL, CTL_GO, 1'b0);
        3'd3:    step = mk_step(OP_DATA, a_nib, 1'b0);
        3'd4:    step = mk_step(OP_SMP_HI, '0, 1'b0);
        3'd5:    step = mk_step(OP_CTRL, CTL_ARM, 1'b0);
        3'd6:    step = mk_step(OP_SMP_LO, '0, 1'b0);
        default: step = mk_step(OP_CTRL, CTL_IDLE, 1'b1);
      endcase
    end else if (mode == MODE_SPLIT) begin
      case (idx)
        3'd0:    step = mk_step(OP_DATA, a_spl, 1'b0);
        3'd1:    step = mk_step(OP_CTRL, CTL_ARM, 1'b0);
        3'd2:    step = mk_step(OP_DATA, a_spl & SPLIT_AND, 1'b0);
        3'd3:    step = mk_step(OP_CTRL, CTL_GO, 1'b0);
        3'd4:    step = mk_step(OP_CTRL, CTL_SPLIT, 1'b0);
        3'd5:    step = mk_step(OP_DATA, a_spl | SPLIT_OR, 1'b0);
        3'd6:    step = mk_step(OP_SMP_PAIR, '0, 1'b0);
        default: step = mk_step(OP_CTRL, CTL_IDLE, 1'b1);
      endcase
    end else begin
      case (idx)
        3'd0:    step = mk_step(OP_DATA, a_byt, 1'b0);
        3'd1:    step = mk_step(OP_CTRL, CTL_ARM, 1'b0);
        3'd2:    step = mk_step(OP_CTRL, CTL_REV_A, 1'b0);
        3'd3:    step = mk_step(OP_CTRL, CTL_REV_B, 1'b0);
        3'd4:    step = mk_step(OP_SMP_BUS, '0, 1'b0);
        default: step = mk_step(OP_CTRL, CTL_IDLE, 1'b1);
      endcase
    end
  end

endmodule

// File: rtl/ppa_hold_timer.sv
module ppa_hold_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_zero,
  output logic         at_limit
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_zero  = (cnt_q == '0);
  assign at_limit = (cnt_q == limit);

endmodule

// File: rtl/ppa_rd_merge.sv
module ppa_rd_merge
  import ppa_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [BYTE_W-1:0] smp_first,
  input  logic [BYTE_W-1:0] smp_second,
  input  logic [BYTE_W-1:0] smp_ctl,
  input  logic [BYTE_W-1:0] smp_bus,
  output logic [BYTE_W-1:0] byte_o
);

  logic unused_bits;
  assign unused_bits = ^{smp_first[2:0], smp_second[3:0], smp_ctl[7:4], smp_ctl[0]};

  always_comb begin
    case (mode)
      MODE_NIB:   byte_o = {smp_second[7:4], smp_first[7:4]};
      MODE_SPLIT: byte_o = {smp_ctl[3:1], smp_first[7:3]};
      default:    byte_o = smp_bus;
    endcase
  end

endmodule

// File: rtl/ppa_regio_engine.sv
module ppa_regio_engine
  import ppa_pkg::*;
#(
  parameter int HOLD_W = 4,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_bank,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [7:0]        req_wdata,
  input  logic [1:0]        req_mode,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  output logic [7:0]        pp_data_o,
  output logic              pp_data_oe,
  output logic [7:0]        pp_ctrl_o,
  input  logic [7:0]        pp_data_i,
  input  logic [7:0]        pp_status_i,
  input  logic [7:0]        pp_ctrl_i
);

  localparam int ADDR_W = IDX_W + 1;

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e                st_q, st_d;
  logic [STEP_W-1:0]  stp_q, stp_d;
  logic               wr_q, wr_d;
  logic [1:0]         mode_q, mode_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [BYTE_W-1:0]  wdat_q, wdat_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic [BYTE_W-1:0]  data_q, data_d, ctrl_q, ctrl_d;
  logic [BYTE_W-1:0]  s1_q, s1_d, s2_q, s2_d, sc_q, sc_d, sb_q, sb_d;
  logic               done_q, done_d;
  logic [BYTE_W-1:0]  rdat_q, rdat_d;

  step_t              cur;
  logic [BYTE_W-1:0]  merged;
  logic               run, accept, is_smp, act, step_end;
  logic               t_zero, t_lim;

  ppa_step_seq u_seq (
    .idx      (stp_q),
    .is_write (wr_q),
    .mode     (mode_q),
    .addr     (addr_q),
    .wdata    (wdat_q),
    .step     (cur)
  );

  ppa_hold_timer #(.W(HOLD_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept | step_end),
    .inc      (run & ~step_end),
    .limit    (hold_q),
    .at_zero  (t_zero),
    .at_limit (t_lim)
  );

  ppa_rd_merge u_merge (
    .mode       (mode_q),
    .smp_first  (s1_q),
    .smp_second (s2_q),
    .smp_ctl    (sc_q),
    .smp_bus    (sb_q),
    .byte_o     (merged)
  );

  always_comb begin
    run      = (st_q == ST_RUN);
    accept   = (st_q == ST_IDLE) && req_valid;
    is_smp   = (cur.op != OP_DATA) && (cur.op != OP_CTRL);
    act      = run && t_zero;
    step_end = run && (is_smp || t_lim);

    st_d   = st_q;   stp_d  = stp_q;
    wr_d   = wr_q;   mode_d = mode_q;
    addr_d = addr_q; wdat_d = wdat_q; hold_d = hold_q;
    data_d = data_q; ctrl_d = ctrl_q;
    s1_d   = s1_q;   s2_d   = s2_q;   sc_d = sc_q; sb_d = sb_q;
    rdat_d = rdat_q; done_d = 1'b0;

    if (accept) begin
      st_d   = ST_RUN;
      stp_d  = '0;
      wr_d   = req_write;
      mode_d = req_mode;
      addr_d = {req_bank, req_index};
      wdat_d = req_wdata;
      hold_d = hold_cfg;
    end

    if (act) begin
      case (cur.op)
        OP_DATA:     data_d = cur.val;
        OP_CTRL:     ctrl_d = cur.val;
        OP_SMP_HI:   s1_d   = pp_status_i;
        OP_SMP_LO:   s2_d   = pp_status_i;
        OP_SMP_PAIR: begin s1_d = pp_status_i; sc_d = pp_ctrl_i; end
        OP_SMP_BUS:  sb_d   = pp_data_i;
        default:     ;
      endcase
    end

    if (step_end) begin
      if (cur.last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        if (!wr_q) rdat_d = merged;
      end else begin
        stp_d = stp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stp_q  <= '0;
      wr_q   <= 1'b0;
      mode_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      hold_q <= '0;
      data_q <= '0;
      ctrl_q <= CTL_IDLE;
      s1_q   <= '0;
      s2_q   <= '0;
      sc_q   <= '0;
      sb_q   <= '0;
      done_q <= 1'b0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      stp_q  <= stp_d;
      wr_q   <= wr_d;
      mode_q <= mode_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      hold_q <= hold_d;
      data_q <= data_d;
      ctrl_q <= ctrl_d;
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      sc_q   <= sc_d;
      sb_q   <= sb_d;
      done_q <= done_d;
      rdat_q <= rdat_d;
    end
  end

  assign busy       = run;
  assign done       = done_q;
  assign rdata      = rdat_q;
  assign pp_data_o  = data_q;
  assign pp_ctrl_o  = ctrl_q;
  assign pp_data_oe = ~ctrl_q[DIR_BIT];

endmodule

// File: rtl/ppa_regio_engine_chk.sv
module ppa_regio_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic [7:0] rdata,
  input logic       pp_data_oe,
  input logic [7:0] pp_ctrl_o
);

  // R9: completion pulse lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion only ends a running transaction
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R9: result holds between completions
  a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

  // R8: a transaction starts only from a presented request
  a_r8_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R10: control rests at its idle value whenever no transaction runs
  a_r10_idle_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pp_ctrl_o == 8'h04));

  // R7: the data port turns around only inside a transaction
  a_r7_turnaround_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    !pp_data_oe |-> busy);

endmodule

bind ppa_regio_engine ppa_regio_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .rdata      (rdata),
  .pp_data_oe (pp_data_oe),
  .pp_ctrl_o  (pp_ctrl_o)
);

// File: tb/ppa_regio_engine_bench.sv
`timescale 1ns/1ps
module ppa_regio_engine_bench;

  typedef struct packed {
    logic       wr;
    logic       bank;
    logic [6:0] idx;
    logic [7:0] wdat;
    logic [1:0] mode;
    logic [3:0] hold;
    logic [7:0] sa;
    logic [7:0] sb;
    logic [7:0] ci;
    logic [7:0] din;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 7'h12, 8'h00, 2'd0, 4'd1, 8'hA5, 8'h3C, 8'h00, 8'h00},
    '{1'b0, 1'b1, 7'h05, 8'h00, 2'd0, 4'd0, 8'h70, 8'hE0, 8'h00, 8'h00},
    '{1'b0, 1'b0, 7'h22, 8'h00, 2'd1, 4'd2, 8'hC8, 8'h00, 8'h0A, 8'h00},
    '{1'b0, 1'b1, 7'h7F, 8'h00, 2'd1, 4'd0, 8'h17, 8'h00, 8'hF5, 8'h00},
    '{1'b0, 1'b0, 7'h33, 8'h00, 2'd2, 4'd1, 8'h00, 8'h00, 8'h00, 8'h96},
    '{1'b0, 1'b1, 7'h01, 8'h00, 2'd3, 4'd3, 8'h00, 8'h00, 8'h00, 8'h5B},
    '{1'b1, 1'b0, 7'h06, 8'hA0, 2'd0, 4'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 7'h10, 8'h3D, 2'd1, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b0, 7'h02, 8'h55, 2'd2, 4'd2, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  logic       clk, rst_n;
  logic       req_valid, req_write, req_bank;
  logic [6:0] req_index;
  logic [7:0] req_wdata;
  logic [1:0] req_mode;
  logic [3:0] hold_cfg;
  logic       busy, done, pp_data_oe;
  logic [7:0] rdata, pp_data_o, pp_ctrl_o, pp_data_i, pp_status_i, pp_ctrl_i;
  logic [7:0] cur_sa, cur_sb, cur_ci, cur_din;

  int n_chk, n_bad, wd;

  ppa_regio_engine u_ppa_regio_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_index(req_index), .req_wdata(req_wdata),
    .req_mode(req_mode), .hold_cfg(hold_cfg), .busy(busy), .done(done),
    .rdata(rdata), .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe),
    .pp_ctrl_o(pp_ctrl_o), .pp_data_i(pp_data_i), .pp_status_i(pp_status_i),
    .pp_ctrl_i(pp_ctrl_i)
  );

  // adapter model: status answers according to the control level
  assign pp_status_i = (pp_ctrl_o == 8'h03 || pp_ctrl_o == 8'h05) ? cur_sa :
                       (pp_ctrl_o == 8'h01) ? cur_sb : 8'h00;
  assign pp_ctrl_i   = cur_ci;
  assign pp_data_i   = cur_din;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // expected port model, built from R1..R5
  logic [15:0] m_dc;
  logic [15:0] exp_log [16];
  int          exp_n, exp_nu, exp_ns;

  task automatic put(input logic [15:0] v);
    exp_nu++;
    if (v != m_dc) begin
      if (exp_n < 16) exp_log[exp_n] = v;
      exp_n++;
      m_dc = v;
    end
  endtask
  task automatic pd(input logic [7:0] d); put({d, m_dc[7:0]}); endtask
  task automatic pc(input logic [7:0] c); put({m_dc[15:8], c}); endtask

  task automatic build_exp(input vec_t v);
    logic [7:0] a, r;
    a = {v.bank, v.idx};          // R1
    exp_n = 0; exp_nu = 0;
    if (v.wr) begin               // R5
      exp_ns = 0;
      pd(a ^ 8'h19); pc(8'h01); pd(v.wdat); pc(8'h03); pc(8'h04);
    end else if (v.mode == 2'd0) begin  // R2
      exp_ns = 2;
      r = a ^ 8'h39;
      pd(r); pc(8'h01); pc(8'h03); pd(r); pc(8'h01); pc(8'h04);
    end else if (v.mode == 2'd1) begin  // R3
      exp_ns = 1;
      r = a ^ 8'h31;
      pd(r); pc(8'h01); pd(r & 8'h37); pc(8'h03); pc(8'h05); pd(r | 8'hF0); pc(8'h04);
    end else begin                      // R4
      exp_ns = 1;
      pd(a ^ 8'h29); pc(8'h01); pc(8'h21); pc(8'h23); pc(8'h04);
    end
  endtask

  function automatic logic [7:0] exp_rd(input vec_t v);
    case (v.mode)
      2'd0:    return {v.sb[7:4], v.sa[7:4]};
      2'd1:    return {v.ci[3:1], v.sa[7:3]};
      default: return v.din;
    endcase
  endfunction

  logic [7:0] last_rd;

  task automatic run_vec(input vec_t v, input int intrude_at);
    logic [15:0] prev, obs [16];
    int          on, cyc, k, bad_i;
    bit          got, oe_bad, oe_low, busy_drop;
    string       tag;
    prev = m_dc;
    build_exp(v);
    @(negedge clk);
    cur_sa = v.sa; cur_sb = v.sb; cur_ci = v.ci; cur_din = v.din;
    req_write = v.wr; req_bank = v.bank; req_index = v.idx; req_wdata = v.wdat;
    req_mode = v.mode; hold_cfg = v.hold; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    on = 0; cyc = 0; got = 0; oe_bad = 0; oe_low = 0; busy_drop = 0;
    while (cyc < 400) begin
      if ({pp_data_o, pp_ctrl_o} != prev) begin
        if (on < 16) obs[on] = {pp_data_o, pp_ctrl_o};
        on++;
        prev = {pp_data_o, pp_ctrl_o};
      end
      if (pp_ctrl_o[5] && pp_data_oe) oe_bad = 1;
      if (pp_ctrl_o[5] && !pp_data_oe) oe_low = 1;
      if (done) begin got = 1; break; end
      if (!busy) busy_drop = 1;
      req_valid = 1'b0;
      if (cyc == intrude_at) begin
        req_write = ~v.wr; req_mode = 2'd2; req_index = 7'h44; req_valid = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    k = exp_nu * (v.hold + 1) + exp_ns;
    chk(got && cyc == k, "R6 latency", cyc, k);
    bad_i = -1;
    for (int i = 0; i < 16; i++)
      if (i < exp_n && bad_i < 0 && obs[i] != exp_log[i]) bad_i = i;
    tag = v.wr ? "R5 write sequence" : (v.bank ? "R1 bank address sequence" :
          (v.mode == 2'd0 ? "R2 nibble sequence" :
          (v.mode == 2'd1 ? "R3 split sequence" : "R4 byte sequence")));
    if (on != exp_n) chk(0, tag, on, exp_n);
    else if (bad_i >= 0) chk(0, tag, obs[bad_i], exp_log[bad_i]);
    else chk(1, tag, 0, 0);
    chk(!oe_bad, "R7 oe low under bit5", oe_bad, 0);
    if (!v.wr && v.mode[1]) chk(oe_low, "R7 byte read turns port", oe_low, 1);
    if (!v.wr) begin
      last_rd = exp_rd(v);
      chk(rdata == last_rd, v.mode == 2'd0 ? "R2 nibble result" :
          (v.mode == 2'd1 ? "R3 split result" : "R4 byte result"), rdata, last_rd);
    end
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(rdata == last_rd, "R9 rdata held", rdata, last_rd);
    if (intrude_at >= 0) begin
      chk(!busy_drop, "R8 busy throughout", busy_drop, 0);
      for (int i = 0; i < 8; i++) begin
        if (busy || done) busy_drop = 1;
        @(negedge clk);
      end
      chk(!busy_drop, "R8 busy request dropped", busy_drop, 0);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; wd = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = 1'b0;
    req_index = '0; req_wdata = '0; req_mode = '0; hold_cfg = '0;
    cur_sa = '0; cur_sb = '0; cur_ci = '0; cur_din = '0;
    m_dc = 16'h0004; last_rd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(pp_ctrl_o == 8'h04, "R10 reset ctrl", pp_ctrl_o, 8'h04);
    chk(pp_data_o == 8'h00, "R10 reset data", pp_data_o, 8'h00);
    chk(pp_data_oe && !busy && !done, "R10 reset flags",
        {pp_data_oe, busy, done}, 3'b100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], -1);

    // R8: request presented mid-transaction is dropped
    run_vec('{1'b0, 1'b0, 7'h4C, 8'h00, 2'd0, 4'd2, 8'h9F, 8'h61, 8'h00, 8'h00}, 3);

    // R9: a write leaves the last read result untouched
    run_vec('{1'b1, 1'b1, 7'h00, 8'hFF, 2'd3, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00}, -1);

    // R10: reset in the middle of a transaction
    @(negedge clk);
    cur_din = 8'h11; req_write = 1'b0; req_mode = 2'd2; req_bank = 1'b0;
    req_index = 7'h08; hold_cfg = 4'd5; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pp_ctrl_o == 8'h04 && pp_data_o == 8'h00 && !busy && pp_data_oe,
        "R10 reset mid transaction", {pp_data_o, pp_ctrl_o}, 16'h0004);
    chk(rdata == 8'h00, "R10 reset clears result", rdata, 8'h00);
    m_dc = 16'h0004; last_rd = 8'h00;
    run_vec('{1'b0, 1'b1, 7'h2A, 8'h00, 2'd2, 4'd0, 8'h00, 8'h00, 8'h00, 8'hC3}, -1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule